// File: doc/BRIEF.md
# I2C Controller Transaction Sequencer

This block runs one complete I2C controller transaction from a descriptor. A start pulse captures the descriptor, which selects one of four transaction shapes: a plain write, a plain read, a write followed by a read joined by a repeated START, or a write that sends two buffers back to back. The descriptor also carries a 7-bit or 10-bit target address and two buffer lengths. The block breaks the transaction into byte-level bus commands: START, repeated START, write byte, read byte and STOP. It hands these commands to a separate bus engine. Data to send comes from two source buffers through a read port. Data that is read lands in two destination buffers through a write port. Only one controller may drive the bus.

Commands go out on a valid/ready stream. The sequencer holds a command stable until the engine takes it with ready high. It then offers nothing more until the engine returns exactly one response, marked by a single cycle of `rsp_valid`. The response side has no back-pressure: the sequencer always waits for it. Destination writes are one-cycle strobes, and the buffer side cannot stall them. The source buffer read port is combinational, so `buf_rd_data` must follow `buf_rd_sel`/`buf_rd_idx` within the same cycle.

The result is a signed 4-bit code. It reads 1 while a transaction runs, 0 on success, -1 when the target refuses a byte, -2 on a bus error, -3 on lost arbitration and -4 on a malformed descriptor. A one-cycle done pulse marks the end of every transaction.

Top module: `i2c_xfer_seq`

## Requirements
- R1: Flags 0x01 issue START, the address byte with bit0=0, `desc_len0` bytes read from source buffer 0 in index order, then STOP, and end with code 0.
- R2: Flags 0x02 with 7-bit addressing issue START, the address byte with bit0=1, `desc_len0` reads written to destination buffer 0 at indices 0 upward, then STOP.
- R3: Flags 0x04 issue START, the write address byte, the buffer 0 data, a repeated START, the address byte with bit0=1, `desc_len1` reads into destination buffer 1, then STOP.
- R4: Flags 0x08 issue START, the write address byte, the buffer 0 data, then the buffer 1 data, then STOP, with no repeated START.
- R5: Flag 0x10 selects 10-bit addressing. The first address byte is {11110, addr[9:8], 0} and is followed by addr[7:0]. Every read phase (flags 0x02 or 0x04) is then entered by a repeated START and the single byte {11110, addr[9:8], 1}.
- R6: Read commands carry `cmd_ack`=1 (acknowledge) for every byte except the last of the phase, which carries `cmd_ack`=0. All other commands carry `cmd_ack`=0.
- R7: If the low four flag bits do not have exactly one bit set, the block issues no command. It pulses done in the cycle after the start pulse, with code -4.
- R8: A response with `rsp_nack` to an address byte or a written data byte stops further data. The block issues STOP and ends with code -1. `rsp_nack` on a read command is ignored.
- R9: A response flagged arbitration-lost ends the transaction at once with code -3 and no STOP. It takes precedence over any bus error or NACK reported in the same response.
- R10: A response flagged bus-error (and not arbitration-lost) ends the transaction at once with code -2 and no STOP.
- R11: The status reads 0 after reset. It reads 1 from the cycle after an accepted start until the done pulse. The done pulse lasts one cycle and shows the final code, which is then held. A start pulse during a transaction is ignored.
- R12: Command encoding on `cmd_op`: 0 START, 1 repeated START, 2 write byte, 3 read byte, 4 STOP. A command stays stable while not accepted, and only one command is outstanding at a time.
- R13: A buffer length of zero produces no data commands for that phase. The rest of the shape is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run the descriptor |
| desc_flags | input | 5 | Shape flags (bits 3:0) and 10-bit address select (bit 4) |
| desc_addr | input | 10 | Target address; bits 6:0 used in 7-bit mode |
| desc_len0 | input | LEN_W | Byte count for buffer 0 |
| desc_len1 | input | LEN_W | Byte count for buffer 1 |
| cmd_valid | output | 1 | Bus command offered |
| cmd_ready | input | 1 | Bus engine takes the command |
| cmd_op | output | 3 | Command code |
| cmd_byte | output | 8 | Byte to send for write commands |
| cmd_ack | output | 1 | Acknowledge to return after a read byte |
| rsp_valid | input | 1 | One-cycle response to the outstanding command |
| rsp_nack | input | 1 | Target refused the written byte |
| rsp_arb_lost | input | 1 | Arbitration lost |
| rsp_bus_err | input | 1 | Misplaced START or STOP seen |
| rsp_byte | input | 8 | Byte received by a read command |
| buf_rd_sel | output | 1 | Source buffer select |
| buf_rd_idx | output | LEN_W | Source buffer index |
| buf_rd_data | input | 8 | Source byte, combinational from select and index |
| buf_wr_valid | output | 1 | Destination write strobe |
| buf_wr_sel | output | 1 | Destination buffer select |
| buf_wr_idx | output | LEN_W | Destination index |
| buf_wr_data | output | 8 | Received byte |
| status | output | 4 | Signed result code |
| done | output | 1 | One-cycle completion pulse |

## Verification
The critical overlap is one response that reports a refused byte and lost arbitration at the same time. The NACK path wants to issue STOP, while the arbitration path must leave the bus alone. The bench injects such a combined response on a data byte. It expects the command log to end at that byte with no STOP and the code to be -3. A second overlap is a start pulse that arrives while a transaction runs, together with a changed descriptor. The bench checks that the commands and result still match the first descriptor.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int FLAG_W = 5;
  localparam int SHAPE_FLAGS = 4;
  localparam int ADDR_W = 10;
  localparam int BYTE_W = 8;
  localparam int OP_W = 3;
  localparam int CODE_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_WRITE  = 3'd2,
    OP_READ   = 3'd3,
    OP_STOP   = 3'd4
  } bus_op_e;

  typedef enum logic [1:0] {
    SH_WR   = 2'd0,
    SH_RD   = 2'd1,
    SH_WRRD = 2'd2,
    SH_WRWR = 2'd3
  } shape_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA,
    ST_RSTART, ST_RADDR, ST_RDATA, ST_STOP
  } seq_state_e;

  localparam logic signed [CODE_W-1:0] RC_BUSY    = 4'sb0001;
  localparam logic signed [CODE_W-1:0] RC_OK      = 4'sb0000;
  localparam logic signed [CODE_W-1:0] RC_NACK    = 4'sb1111;
  localparam logic signed [CODE_W-1:0] RC_BUSERR  = 4'sb1110;
  localparam logic signed [CODE_W-1:0] RC_ARBLOST = 4'sb1101;
  localparam logic signed [CODE_W-1:0] RC_USAGE   = 4'sb1100;
endpackage

// File: rtl/i2c_seq_decode.sv
module i2c_seq_decode
  import i2c_seq_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  output logic              ok,
  output shape_e            shape,
  output logic              ten_bit
);
  logic [SHAPE_FLAGS-1:0] sel;
  assign sel     = flags[SHAPE_FLAGS-1:0];
  assign ok      = ($countones(sel) == 1);
  assign ten_bit = flags[SHAPE_FLAGS];

  always_comb begin
    shape = SH_WR;
    if (sel[1]) shape = SH_RD;
    if (sel[2]) shape = SH_WRRD;
    if (sel[3]) shape = SH_WRWR;
  end
endmodule

// File: rtl/i2c_seq_addr.sv
module i2c_seq_addr
  import i2c_seq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              ten_bit,
  input  logic              rd,
  output logic [BYTE_W-1:0] first_byte,
  output logic [BYTE_W-1:0] second_byte
);
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  assign first_byte  = ten_bit ? {TEN_PREFIX, addr[ADDR_W-1:ADDR_W-2], rd}
                               : {addr[6:0], rd};
  assign second_byte = addr[BYTE_W-1:0];
endmodule

// File: rtl/i2c_seq_cursor.sv
module i2c_seq_cursor #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sel_in,
  input  logic             adv,
  input  logic [LEN_W-1:0] len0,
  input  logic [LEN_W-1:0] len1,
  output logic             sel,
  output logic [LEN_W-1:0] idx,
  output logic             at_end,
  output logic             is_last
);
  logic [LEN_W-1:0] cur_len;
  assign cur_len = sel ? len1 : len0;
  assign at_end  = (idx == cur_len);
  assign is_last = (({1'b0, idx} + 1'b1) == {1'b0, cur_len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= 1'b0;
      idx <= '0;
    end else if (clr) begin
      sel <= sel_in;
      idx <= '0;
    end else if (adv) begin
      idx <= idx + 1'b1;
    end
  end

  // R13: the index never runs past the active length
  assert_idx_bound_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |-> !at_end);
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [FLAG_W-1:0]        desc_flags,
  input  logic [ADDR_W-1:0]        desc_addr,
  input  logic [LEN_W-1:0]         desc_len0,
  input  logic [LEN_W-1:0]         desc_len1,
  output logic                     cmd_valid,
  input  logic                     cmd_ready,
  output logic [OP_W-1:0]          cmd_op,
  output logic [BYTE_W-1:0]        cmd_byte,
  output logic                     cmd_ack,
  input  logic                     rsp_valid,
  input  logic                     rsp_nack,
  input  logic                     rsp_arb_lost,
  input  logic                     rsp_bus_err,
  input  logic [BYTE_W-1:0]        rsp_byte,
  output logic                     buf_rd_sel,
  output logic [LEN_W-1:0]         buf_rd_idx,
  input  logic [BYTE_W-1:0]        buf_rd_data,
  output logic                     buf_wr_valid,
  output logic                     buf_wr_sel,
  output logic [LEN_W-1:0]         buf_wr_idx,
  output logic [BYTE_W-1:0]        buf_wr_data,
  output logic signed [CODE_W-1:0] status,
  output logic                     done
);
  seq_state_e state;
  logic waiting;
  shape_e shape_q;
  logic ten_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0] len0_q, len1_q;
  logic signed [CODE_W-1:0] code_q;

  logic dec_ok, dec_ten;
  shape_e dec_shape;
  i2c_seq_decode u_decode (
    .flags(desc_flags), .ok(dec_ok), .shape(dec_shape), .ten_bit(dec_ten)
  );

  logic addr_rd;
  logic [BYTE_W-1:0] addr_first, addr_second;
  assign addr_rd = (state == ST_RADDR) || (shape_q == SH_RD && !ten_q);
  i2c_seq_addr u_addr (
    .addr(addr_q), .ten_bit(ten_q), .rd(addr_rd),
    .first_byte(addr_first), .second_byte(addr_second)
  );

  logic accept, got, rsp_err;
  assign accept  = cmd_valid && cmd_ready;
  assign got     = waiting && rsp_valid;
  assign rsp_err = rsp_arb_lost || rsp_bus_err;

  logic cur_clr, cur_sel_in, cur_adv, cur_sel, cur_at_end, cur_last;
  logic [LEN_W-1:0] cur_idx;
  logic wphase_end, rphase_end;
  assign wphase_end = (state == ST_WDATA) && !waiting && cur_at_end;
  assign rphase_end = (state == ST_RDATA) && !waiting && cur_at_end;
  assign cur_clr = (state == ST_IDLE)
                || (wphase_end && shape_q == SH_WRWR && !cur_sel)
                || (got && !rsp_err && !rsp_nack && state == ST_RADDR);
  assign cur_sel_in = (state == ST_WDATA) ? 1'b1 :
                      (state == ST_RADDR) ? (shape_q == SH_WRRD) : 1'b0;
  assign cur_adv = got && !rsp_err &&
                   ((state == ST_WDATA && !rsp_nack) || state == ST_RDATA);

  i2c_seq_cursor #(.LEN_W(LEN_W)) u_cursor (
    .clk(clk), .rst_n(rst_n), .clr(cur_clr), .sel_in(cur_sel_in),
    .adv(cur_adv), .len0(len0_q), .len1(len1_q), .sel(cur_sel),
    .idx(cur_idx), .at_end(cur_at_end), .is_last(cur_last)
  );

  assign buf_rd_sel = cur_sel;
  assign buf_rd_idx = cur_idx;

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_START;
    cmd_byte  = '0;
    cmd_ack   = 1'b0;
    if (!waiting) begin
      case (state)
        ST_START:  cmd_valid = 1'b1;
        ST_ADDR_HI, ST_RADDR: begin
          cmd_valid = 1'b1;
          cmd_op    = OP_WRITE;
          cmd_byte  = addr_first;
        end
        ST_ADDR_LO: begin
          cmd_valid = 1'b1;
          cmd_op    = OP_WRITE;
          cmd_byte  = addr_second;
        end
        ST_WDATA: begin
          cmd_valid = !cur_at_end;
          cmd_op    = OP_WRITE;
          cmd_byte  = buf_rd_data;
        end
        ST_RSTART: begin
          cmd_valid = 1'b1;
          cmd_op    = OP_RSTART;
        end
        ST_RDATA: begin
          cmd_valid = !cur_at_end;
          cmd_op    = OP_READ;
          cmd_ack   = !cur_last;
        end
        ST_STOP: begin
          cmd_valid = 1'b1;
          cmd_op    = OP_STOP;
        end
        default: cmd_valid = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      waiting      <= 1'b0;
      shape_q      <= SH_WR;
      ten_q        <= 1'b0;
      addr_q       <= '0;
      len0_q       <= '0;
      len1_q       <= '0;
      code_q       <= RC_OK;
      status       <= RC_OK;
      done         <= 1'b0;
      buf_wr_valid <= 1'b0;
      buf_wr_sel   <= 1'b0;
      buf_wr_idx   <= '0;
      buf_wr_data  <= '0;
    end else begin
      done         <= 1'b0;
      buf_wr_valid <= 1'b0;
      if (accept) waiting <= 1'b1;
      if (state == ST_IDLE) begin
        if (start) begin
          if (!dec_ok) begin
            status <= RC_USAGE;
            done   <= 1'b1;
          end else begin
            shape_q <= dec_shape;
            ten_q   <= dec_ten;
            addr_q  <= desc_addr;
            len0_q  <= desc_len0;
            len1_q  <= desc_len1;
            code_q  <= RC_OK;
            status  <= RC_BUSY;
            state   <= ST_START;
          end
        end
      end else if (got) begin
        waiting <= 1'b0;
        if (rsp_arb_lost) begin
          state  <= ST_IDLE;
          status <= RC_ARBLOST;
          done   <= 1'b1;
        end else if (rsp_bus_err) begin
          state  <= ST_IDLE;
          status <= RC_BUSERR;
          done   <= 1'b1;
        end else begin
          case (state)
            ST_START: state <= ST_ADDR_HI;
            ST_ADDR_HI: begin
              if (rsp_nack) begin
                code_q <= RC_NACK;
                state  <= ST_STOP;
              end else if (ten_q) state <= ST_ADDR_LO;
              else if (shape_q == SH_RD) state <= ST_RDATA;
              else state <= ST_WDATA;
            end
            ST_ADDR_LO: begin
              if (rsp_nack) begin
                code_q <= RC_NACK;
                state  <= ST_STOP;
              end else if (shape_q == SH_RD) state <= ST_RSTART;
              else state <= ST_WDATA;
            end
            ST_WDATA: begin
              if (rsp_nack) begin
                code_q <= RC_NACK;
                state  <= ST_STOP;
              end
            end
            ST_RSTART: state <= ST_RADDR;
            ST_RADDR: begin
              if (rsp_nack) begin
                code_q <= RC_NACK;
                state  <= ST_STOP;
              end else state <= ST_RDATA;
            end
            ST_RDATA: begin
              buf_wr_valid <= 1'b1;
              buf_wr_sel   <= cur_sel;
              buf_wr_idx   <= cur_idx;
              buf_wr_data  <= rsp_byte;
            end
            ST_STOP: begin
              state  <= ST_IDLE;
              status <= code_q;
              done   <= 1'b1;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end else if (wphase_end) begin
        if (shape_q == SH_WRWR && !cur_sel) state <= ST_WDATA;
        else if (shape_q == SH_WRRD) state <= ST_RSTART;
        else state <= ST_STOP;
      end else if (rphase_end) begin
        state <= ST_STOP;
      end
    end
  end

  // R12: an offered command is held until taken
  assert_cmd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op)));
  // R12: nothing new is offered right after a hand-off
  assert_one_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_valid);
  // R11: code reads 1 while a transaction is active
  assert_busy_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (status == RC_BUSY));
  // R11: the done pulse never carries the running code
  assert_done_final_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status != RC_BUSY));
  // R7: malformed descriptor finishes next cycle without bus activity
  assert_usage_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state == ST_IDLE && !dec_ok) |=> (done && status == RC_USAGE && !cmd_valid));
  // R9: lost arbitration ends at once
  assert_arb_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (got && rsp_arb_lost) |=> (done && status == RC_ARBLOST));
  // R2: destination writes only follow a response
  assert_wr_after_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_valid |-> $past(rsp_valid));
endmodule

// File: tb/i2c_xfer_seq_tb.sv
module i2c_xfer_seq_tb;
  import i2c_seq_pkg::*;
  localparam int LEN_W = 4;
  localparam int BUF_N = 1 << LEN_W;
  localparam int LOG_N = 128;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start;
  logic [4:0] desc_flags;
  logic [9:0] desc_addr;
  logic [LEN_W-1:0] desc_len0, desc_len1;
  logic cmd_valid, cmd_ready, cmd_ack;
  logic [2:0] cmd_op;
  logic [7:0] cmd_byte;
  logic rsp_valid, rsp_nack, rsp_arb_lost, rsp_bus_err;
  logic [7:0] rsp_byte;
  logic buf_rd_sel, buf_wr_valid, buf_wr_sel;
  logic [LEN_W-1:0] buf_rd_idx, buf_wr_idx;
  logic [7:0] buf_rd_data, buf_wr_data;
  logic signed [3:0] status;
  logic done;

  logic [7:0] src0 [BUF_N];
  logic [7:0] src1 [BUF_N];
  assign buf_rd_data = buf_rd_sel ? src1[buf_rd_idx] : src0[buf_rd_idx];

  i2c_xfer_seq #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .desc_flags(desc_flags),
    .desc_addr(desc_addr), .desc_len0(desc_len0), .desc_len1(desc_len1),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_ack(cmd_ack), .rsp_valid(rsp_valid),
    .rsp_nack(rsp_nack), .rsp_arb_lost(rsp_arb_lost), .rsp_bus_err(rsp_bus_err),
    .rsp_byte(rsp_byte), .buf_rd_sel(buf_rd_sel), .buf_rd_idx(buf_rd_idx),
    .buf_rd_data(buf_rd_data), .buf_wr_valid(buf_wr_valid),
    .buf_wr_sel(buf_wr_sel), .buf_wr_idx(buf_wr_idx), .buf_wr_data(buf_wr_data),
    .status(status), .done(done)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // bus engine model and logs
  int log_n = 0, wr_n = 0;
  int log_op [LOG_N];
  int log_byte [LOG_N];
  int log_ack [LOG_N];
  int wlog_sel [LOG_N];
  int wlog_idx [LOG_N];
  int wlog_dat [LOG_N];
  int inj_at = -1, inj_kind = 0, ready_pct = 70;
  int pend = -1, pend_idx = 0;
  bit rdy;

  function automatic int rd_val(input int n);
    return (n * 37 + 11) & 255;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      cmd_ready <= 1'b0; rsp_valid <= 1'b0; rsp_nack <= 1'b0;
      rsp_arb_lost <= 1'b0; rsp_bus_err <= 1'b0; rsp_byte <= '0;
      pend = -1;
    end else begin
      rsp_valid <= 1'b0; rsp_nack <= 1'b0; rsp_arb_lost <= 1'b0;
      rsp_bus_err <= 1'b0; rsp_byte <= '0;
      if (pend > 0) pend = pend - 1;
      if (pend == 0) begin
        rsp_valid <= 1'b1;
        if (log_op[pend_idx] == 3) rsp_byte <= 8'(rd_val(pend_idx));
        if (pend_idx == inj_at) begin
          case (inj_kind)
            1: rsp_nack <= 1'b1;
            2: rsp_arb_lost <= 1'b1;
            3: rsp_bus_err <= 1'b1;
            4: begin rsp_arb_lost <= 1'b1; rsp_nack <= 1'b1; end
            default: ;
          endcase
        end
        pend = -1;
      end
      if (buf_wr_valid && wr_n < LOG_N) begin
        wlog_sel[wr_n] = int'(buf_wr_sel);
        wlog_idx[wr_n] = int'(buf_wr_idx);
        wlog_dat[wr_n] = int'(buf_wr_data);
        wr_n++;
      end
      rdy = ($urandom_range(99) < ready_pct);
      cmd_ready <= rdy;
      if (cmd_valid && rdy && log_n < LOG_N) begin
        log_op[log_n]   = int'(cmd_op);
        log_byte[log_n] = int'(cmd_byte);
        log_ack[log_n]  = int'(cmd_ack);
        pend_idx = log_n;
        pend = 1 + $urandom_range(2);
        log_n++;
      end
    end
  end

  // expected command list
  int exp_n, exp_ok;
  int exp_op [LOG_N];
  int exp_byte [LOG_N];
  int exp_ack [LOG_N];
  int exp_sel [LOG_N];
  int exp_idx [LOG_N];

  task automatic push(input int op, input int b, input int ack, input int s, input int i);
    exp_op[exp_n] = op; exp_byte[exp_n] = b; exp_ack[exp_n] = ack;
    exp_sel[exp_n] = s; exp_idx[exp_n] = i; exp_n++;
  endtask

  task automatic build_exp(input logic [4:0] fl, input logic [9:0] ad,
                           input int l0, input int l1);
    int ones, shp, hi_w, hi_r, lo7;
    ones = int'(fl[0]) + int'(fl[1]) + int'(fl[2]) + int'(fl[3]);
    exp_n = 0;
    exp_ok = (ones == 1);
    if (!exp_ok) return;
    shp = fl[1] ? 1 : fl[2] ? 2 : fl[3] ? 3 : 0;
    hi_w = (5'b11110 << 3) | (int'(ad[9:8]) << 1);
    hi_r = hi_w | 1;
    lo7 = int'(ad[6:0]) << 1;
    push(0, 0, 0, 0, 0);
    if (fl[4]) begin
      push(2, hi_w, 0, 0, 0);
      push(2, int'(ad[7:0]), 0, 0, 0);
    end else push(2, (shp == 1) ? (lo7 | 1) : lo7, 0, 0, 0);
    if (shp != 1) for (int i = 0; i < l0; i++) push(2, int'(src0[i]), 0, 0, 0);
    if (shp == 3) for (int i = 0; i < l1; i++) push(2, int'(src1[i]), 0, 0, 0);
    if (shp == 2 || (shp == 1 && fl[4])) begin
      push(1, 0, 0, 0, 0);
      push(2, fl[4] ? hi_r : (lo7 | 1), 0, 0, 0);
    end
    if (shp == 1) for (int i = 0; i < l0; i++) push(3, 0, (i != l0 - 1) ? 1 : 0, 0, i);
    if (shp == 2) for (int i = 0; i < l1; i++) push(3, 0, (i != l1 - 1) ? 1 : 0, 1, i);
    push(4, 0, 0, 0, 0);
  endtask

  task automatic run_txn(input logic [4:0] fl, input logic [9:0] ad,
                         input int l0, input int l1, input int kind,
                         input int pick, input bit retrig, input string tag);
    int k, ecode, cyc, nw, ew, seen;
    build_exp(fl, ad, l0, l1);
    k = -1;
    ecode = exp_ok ? 0 : -4;
    if (exp_ok && kind != 0) begin
      if (kind == 1) begin
        nw = 0;
        for (int i = 0; i < exp_n; i++) if (exp_op[i] == 2) nw++;
        seen = 0;
        for (int i = 0; i < exp_n; i++)
          if (exp_op[i] == 2) begin
            if (seen == pick % nw) k = i;
            seen++;
          end
        exp_n = k + 1;
        push(4, 0, 0, 0, 0);
        ecode = -1;
      end else begin
        k = pick % exp_n;
        exp_n = k + 1;
        ecode = (kind == 3) ? -2 : -3;
      end
    end
    inj_kind = kind; inj_at = k; log_n = 0; wr_n = 0;
    @(negedge clk);
    desc_flags = fl; desc_addr = ad;
    desc_len0 = LEN_W'(l0); desc_len1 = LEN_W'(l1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!exp_ok) begin
      chk(done === 1'b1 && status == -4, "R7", {tag, " usage fault next cycle"},
          int'(status), -4);
    end else begin
      chk(status == 1 && done == 1'b0, "R11", {tag, " busy code"}, int'(status), 1);
      if (retrig) begin
        desc_flags = 5'h02; desc_len0 = 4'd7; desc_addr = 10'h3FF;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(done === 1'b1, "R11", {tag, " done seen"}, int'(done), 1);
    chk(int'(status) == ecode, tag, "final code", int'(status), ecode);
    chk(log_n == exp_n, tag, "command count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_op[i] == exp_op[i], "R12", {tag, " command op"}, log_op[i], exp_op[i]);
      if (exp_op[i] == 2)
        chk(log_byte[i] == exp_byte[i], tag, "command byte", log_byte[i], exp_byte[i]);
      chk(log_ack[i] == exp_ack[i], "R6", {tag, " ack bit"}, log_ack[i], exp_ack[i]);
    end
    ew = 0;
    for (int i = 0; i < exp_n; i++)
      if (exp_op[i] == 3 && !(i == k && kind != 1)) begin
        if (ew < wr_n) begin
          chk(wlog_sel[ew] == exp_sel[i] && wlog_idx[ew] == exp_idx[i], tag,
              "dest slot", wlog_sel[ew] * 100 + wlog_idx[ew], exp_sel[i] * 100 + exp_idx[i]);
          chk(wlog_dat[ew] == rd_val(i), tag, "dest data", wlog_dat[ew], rd_val(i));
        end
        ew++;
      end
    chk(wr_n == ew, tag, "dest write count", wr_n, ew);
    @(negedge clk);
    chk(done == 1'b0 && int'(status) == ecode, "R11", {tag, " code held, pulse ends"},
        int'(status), ecode);
    inj_at = -1; inj_kind = 0;
  endtask

  task automatic fill_src();
    for (int i = 0; i < BUF_N; i++) begin
      src0[i] = 8'($urandom);
      src1[i] = 8'($urandom);
    end
  endtask

  initial begin
    int seed_dummy, fl, kd;
    seed_dummy = $urandom(32'h5EED_0042);
    rst_n = 1'b0; start = 1'b0; desc_flags = '0; desc_addr = '0;
    desc_len0 = '0; desc_len1 = '0;
    fill_src();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 0 && done == 0 && cmd_valid == 0 && buf_wr_valid == 0, "R11",
        "reset state", int'(status), 0);

    run_txn(5'h01, 10'h05A, 3, 0, 0, 0, 0, "R1");
    run_txn(5'h02, 10'h031, 4, 0, 0, 0, 0, "R2");
    run_txn(5'h04, 10'h06E, 2, 3, 0, 0, 0, "R3");
    run_txn(5'h08, 10'h012, 2, 2, 0, 0, 0, "R4");
    run_txn(5'h12, 10'h2C7, 2, 0, 0, 0, 0, "R5");
    run_txn(5'h14, 10'h19B, 1, 2, 0, 0, 0, "R5");
    run_txn(5'h11, 10'h3A4, 2, 0, 0, 0, 0, "R5");
    run_txn(5'h02, 10'h044, 1, 0, 0, 0, 0, "R6");
    run_txn(5'h00, 10'h044, 1, 0, 0, 0, 0, "R7");
    run_txn(5'h03, 10'h044, 1, 0, 0, 0, 0, "R7");
    run_txn(5'h10, 10'h044, 1, 0, 0, 0, 0, "R7");
    run_txn(5'h0C, 10'h044, 1, 0, 0, 0, 0, "R7");
    run_txn(5'h01, 10'h050, 3, 0, 1, 0, 0, "R8");
    run_txn(5'h04, 10'h050, 3, 2, 1, 3, 0, "R8");
    run_txn(5'h08, 10'h050, 2, 2, 2, 2, 0, "R9");
    run_txn(5'h02, 10'h050, 3, 0, 2, 3, 0, "R9");
    run_txn(5'h01, 10'h050, 2, 0, 3, 4, 0, "R10");
    run_txn(5'h04, 10'h050, 2, 2, 4, 2, 0, "R9");
    run_txn(5'h01, 10'h050, 0, 0, 0, 0, 0, "R13");
    run_txn(5'h08, 10'h050, 0, 2, 0, 0, 0, "R13");
    run_txn(5'h04, 10'h050, 2, 0, 0, 0, 0, "R13");
    run_txn(5'h01, 10'h060, 4, 0, 0, 0, 1, "R11");

    ready_pct = 40;
    for (int t = 0; t < 80; t++) begin
      fill_src();
      fl = (1 << $urandom_range(3)) | ($urandom_range(1) << 4);
      if ($urandom_range(9) == 0) fl = $urandom_range(31);
      kd = ($urandom_range(3) == 0) ? $urandom_range(1, 4) : 0;
      run_txn(5'(fl), 10'($urandom), $urandom_range(5), $urandom_range(5), kd,
              $urandom_range(63), 0, "R12 random");
      if (t == 40) ready_pct = 90;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule